// File: doc/BRIEF.md
# Pulse-swallow PLL divider chain

This block is the digital counter section of an integer-N frequency synthesizer. A reference divider brings the reference clock down to the comparison rate. A main divider brings the oscillator clock down to the same rate. The main divider is a dual-modulus pulse-swallow chain: a 16/17 prescaler, modelled as a synthesizable counter on the oscillator clock, is followed by a program counter and a swallow counter. Each comparison period, the prescaler divides by 17 for the first A prescaler cycles and by 16 for the remaining N−A cycles. With the defaults (N = 271, A = 10) the total oscillator division is 16·271+10 = 4346. A 19.68 MHz reference divided by 328 gives 60 kHz, which puts the oscillator at 260.76 MHz.

A ratio-select input picks one of two fixed reference ratios: 328 when low, 330 when high. A new ratio is only picked up when the reference counter reloads. A power-save input (`ps_en` low) holds every counter at its terminal state and silences the outputs. When `ps_en` returns high, both dividers start from that terminal state, so the first divided pulse of each domain appears at once and the two are aligned. Each divided output is a one-cycle pulse in its own clock domain. `ps_en` and `ratio_sel` are expected to change away from the edges of both clocks. The phase detector, charge pump and oscillator sit outside this block.

Top module: `psw_divchain`

## Requirements
- R1: While `rst_n` is low, `ref_pulse`, `main_pulse` and `mod_ctl` are low. While `ps_en` is low, `ref_pulse` and `main_pulse` are low from the first edge of their domain that samples it low. `mod_ctl` is low from the second `vco_clk` edge that samples it low.
- R2: In steady operation, `main_pulse` recurs every BASE·N+A = 4346 `vco_clk` cycles.
- R3: `mod_ctl` is high (prescaler dividing by BASE+1 = 17) for exactly A·(BASE+1) = 170 cycles, beginning in the cycle after each `main_pulse`. It is low for the rest of the period, including the `main_pulse` cycle.
- R4: With `ratio_sel` low (encoding 0), `ref_pulse` recurs every 328 `ref_clk` cycles.
- R5: With `ratio_sel` high (encoding 1), `ref_pulse` recurs every 330 `ref_clk` cycles.
- R6: `ratio_sel` is sampled only at the `ref_clk` edge that ends a `ref_pulse` cycle. That value sets the length of the period that follows, and a change in mid-count leaves the running period unchanged.
- R7: After `ps_en` rises, each output pulse is asserted in the cycle right after the first edge of its own clock that samples `ps_en` high.
- R8: Each `main_pulse` and each `ref_pulse` lasts exactly one cycle of its clock.
- R9: No pulse appears during power save. After it, the chain resumes from the terminal state (per R7) and the main period is again 4346 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Oscillator clock feeding the prescaler and program counters |
| ref_clk | input | 1 | Reference clock feeding the reference counter |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| ps_en | input | 1 | High: operate; low: power save with counters held at terminal state |
| ratio_sel | input | 1 | Reference ratio choice: 0 selects R_LO, 1 selects R_HI |
| ref_pulse | output | 1 | One-cycle pulse at reference terminal count (ref_clk domain) |
| main_pulse | output | 1 | One-cycle pulse at main terminal count (vco_clk domain) |
| mod_ctl | output | 1 | Prescaler modulus: 1 = divide by BASE+1, 0 = divide by BASE |

## Verification
The assertions check on every cycle that both pulses last one cycle and that the outputs stay quiet during power save. They also check that `mod_ctl` rises only right after a main pulse, that a pulse appears in the first active cycle after leaving save, and, through gap counters, that every uninterrupted period is 4346 oscillator cycles or one of the two reference ratios. Only the bench scenarios can show that the 17-modulus window is exactly 170 cycles, that the two ratios appear for the right select values, and that a select change in mid-count waits for the reload while one made in the pulse cycle takes effect at once. The behavioural phase model in the bench covers these and the resumption after a long power-save interval.

// File: rtl/psw_pkg.sv
package psw_pkg;
   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic int unsigned main_total(input int unsigned base,
                                              input int unsigned n,
                                              input int unsigned a);
      return base * n + a;
   endfunction
endpackage

// File: rtl/psw_prescaler.sv
module psw_prescaler #(
   parameter int unsigned BASE = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic mod_hi_next,
   output logic tc
);
   localparam int unsigned CW = $clog2(BASE + 1);
   localparam logic [CW-1:0] LOAD_HI = CW'(BASE);
   localparam logic [CW-1:0] LOAD_LO = CW'(BASE - 1);

   logic [CW-1:0] cnt;

   assign tc = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run) begin
         cnt <= '0;
      end else if (tc) begin
         cnt <= mod_hi_next ? LOAD_HI : LOAD_LO;
      end else begin
         cnt <= cnt - 1'b1;
      end
   end
endmodule

// File: rtl/psw_swallow.sv
module psw_swallow #(
   parameter int unsigned N_CNT = 271,
   parameter int unsigned A_CNT = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic pre_tc,
   output logic mod_hi,
   output logic mod_hi_next,
   output logic wrap
);
   localparam int unsigned KW = (N_CNT > 2) ? $clog2(N_CNT) : 1;
   localparam logic [KW-1:0] LAST = KW'(N_CNT - 1);

   logic [KW-1:0] idx;
   logic [KW-1:0] idx_nxt;
   logic          at_last;

   assign at_last = (idx == LAST);
   assign idx_nxt = at_last ? '0 : idx + 1'b1;
   assign wrap    = pre_tc & at_last;

   generate
      if (A_CNT == 0) begin : g_no_swallow
         assign mod_hi      = 1'b0;
         assign mod_hi_next = 1'b0;
      end else begin : g_swallow
         localparam logic [KW-1:0] A_LIM = KW'(A_CNT);
         assign mod_hi      = (idx < A_LIM);
         assign mod_hi_next = (idx_nxt < A_LIM);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx <= LAST;
      end else if (!run) begin
         idx <= LAST;
      end else if (pre_tc) begin
         idx <= idx_nxt;
      end
   end
endmodule

// File: rtl/psw_refdiv.sv
module psw_refdiv
   import psw_pkg::*;
#(
   parameter int unsigned R_LO = 328,
   parameter int unsigned R_HI = 330
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic sel,
   output logic tc
);
   localparam int unsigned RMAX = max_u(R_LO, R_HI);
   localparam int unsigned RW   = $clog2(RMAX);
   localparam logic [RW-1:0] LOAD_LO = RW'(R_LO - 1);
   localparam logic [RW-1:0] LOAD_HI = RW'(R_HI - 1);

   logic [RW-1:0] cnt;

   assign tc = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run) begin
         cnt <= '0;
      end else if (tc) begin
         cnt <= sel ? LOAD_HI : LOAD_LO;
      end else begin
         cnt <= cnt - 1'b1;
      end
   end
endmodule

// File: rtl/psw_divchain.sv
module psw_divchain #(
   parameter int unsigned BASE  = 16,
   parameter int unsigned N_CNT = 271,
   parameter int unsigned A_CNT = 10,
   parameter int unsigned R_LO  = 328,
   parameter int unsigned R_HI  = 330
) (
   input  logic vco_clk,
   input  logic ref_clk,
   input  logic rst_n,
   input  logic ps_en,
   input  logic ratio_sel,
   output logic ref_pulse,
   output logic main_pulse,
   output logic mod_ctl
);
   generate
      if (BASE < 2) begin : g_bad_base
         $error("psw_divchain: BASE must be at least 2");
      end
      if (N_CNT < 2 || A_CNT >= N_CNT) begin : g_bad_na
         $error("psw_divchain: need N_CNT >= 2 and A_CNT < N_CNT");
      end
      if (R_LO < 2 || R_HI < 2) begin : g_bad_r
         $error("psw_divchain: reference ratios must be at least 2");
      end
   endgenerate

   logic act_v;
   logic act_r;
   logic pre_tc;
   logic mod_hi_next;
   logic wrap;
   logic r_tc;

   always_ff @(posedge vco_clk or negedge rst_n) begin
      if (!rst_n) act_v <= 1'b0;
      else        act_v <= ps_en;
   end

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) act_r <= 1'b0;
      else        act_r <= ps_en;
   end

   psw_prescaler #(.BASE(BASE)) u_pre (
      .clk         (vco_clk),
      .rst_n       (rst_n),
      .run         (act_v),
      .mod_hi_next (mod_hi_next),
      .tc          (pre_tc)
   );

   psw_swallow #(.N_CNT(N_CNT), .A_CNT(A_CNT)) u_swl (
      .clk         (vco_clk),
      .rst_n       (rst_n),
      .run         (act_v),
      .pre_tc      (pre_tc),
      .mod_hi      (mod_ctl),
      .mod_hi_next (mod_hi_next),
      .wrap        (wrap)
   );

   psw_refdiv #(.R_LO(R_LO), .R_HI(R_HI)) u_ref (
      .clk   (ref_clk),
      .rst_n (rst_n),
      .run   (act_r),
      .sel   (ratio_sel),
      .tc    (r_tc)
   );

   assign main_pulse = act_v & wrap;
   assign ref_pulse  = act_r & r_tc;
endmodule

// File: rtl/psw_divchain_chk.sv
module psw_divchain_chk
   import psw_pkg::*;
#(
   parameter int unsigned BASE  = 16,
   parameter int unsigned N_CNT = 271,
   parameter int unsigned A_CNT = 10,
   parameter int unsigned R_LO  = 328,
   parameter int unsigned R_HI  = 330
) (
   input logic vco_clk,
   input logic ref_clk,
   input logic rst_n,
   input logic ps_en,
   input logic ref_pulse,
   input logic main_pulse,
   input logic mod_ctl
);
   localparam int unsigned TOTAL = main_total(BASE, N_CNT, A_CNT);
   localparam int unsigned MW    = $clog2(TOTAL + 2);
   localparam int unsigned RGW   = $clog2(max_u(R_LO, R_HI) + 2);

   logic [MW-1:0]  m_gap;
   logic           m_armed;
   logic [RGW-1:0] r_gap;
   logic           r_armed;

   always_ff @(posedge vco_clk or negedge rst_n) begin
      if (!rst_n) begin
         m_gap   <= '0;
         m_armed <= 1'b0;
      end else begin
         if (!ps_en)          m_armed <= 1'b0;
         else if (main_pulse) m_armed <= 1'b1;
         if (main_pulse)      m_gap <= MW'(1);
         else if (m_gap != '1) m_gap <= m_gap + 1'b1;
      end
   end

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         r_gap   <= '0;
         r_armed <= 1'b0;
      end else begin
         if (!ps_en)          r_armed <= 1'b0;
         else if (ref_pulse)  r_armed <= 1'b1;
         if (ref_pulse)       r_gap <= RGW'(1);
         else if (r_gap != '1) r_gap <= r_gap + 1'b1;
      end
   end

   assert_save_quiet_main_R1: assert property (@(posedge vco_clk) disable iff (!rst_n)
      !$past(ps_en) |-> !main_pulse);
   assert_save_quiet_ref_R1: assert property (@(posedge ref_clk) disable iff (!rst_n)
      !$past(ps_en) |-> !ref_pulse);
   assert_save_quiet_mod_R1: assert property (@(posedge vco_clk) disable iff (!rst_n)
      (!$past(ps_en) && !$past(ps_en, 2)) |-> !mod_ctl);
   assert_main_period_R2: assert property (@(posedge vco_clk) disable iff (!rst_n)
      (main_pulse && m_armed) |-> (m_gap == MW'(TOTAL)));
   assert_mod_rise_R3: assert property (@(posedge vco_clk) disable iff (!rst_n)
      $rose(mod_ctl) |-> $past(main_pulse));
   assert_ref_period_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (ref_pulse && r_armed) |-> (r_gap == RGW'(R_LO) || r_gap == RGW'(R_HI)));
   assert_first_main_R7: assert property (@(posedge vco_clk) disable iff (!rst_n)
      ($past(ps_en) && !$past(ps_en, 2)) |-> main_pulse);
   assert_first_ref_R7: assert property (@(posedge ref_clk) disable iff (!rst_n)
      ($past(ps_en) && !$past(ps_en, 2)) |-> ref_pulse);
   assert_main_single_R8: assert property (@(posedge vco_clk) disable iff (!rst_n)
      main_pulse |=> !main_pulse);
   assert_ref_single_R8: assert property (@(posedge ref_clk) disable iff (!rst_n)
      ref_pulse |=> !ref_pulse);
endmodule

bind psw_divchain psw_divchain_chk #(
   .BASE(BASE), .N_CNT(N_CNT), .A_CNT(A_CNT), .R_LO(R_LO), .R_HI(R_HI)
) u_chk (
   .vco_clk    (vco_clk),
   .ref_clk    (ref_clk),
   .rst_n      (rst_n),
   .ps_en      (ps_en),
   .ref_pulse  (ref_pulse),
   .main_pulse (main_pulse),
   .mod_ctl    (mod_ctl)
);

// File: tb/sim_psw_divchain.sv
module sim_psw_divchain;
   localparam int BASE  = 16;
   localparam int N     = 271;
   localparam int A     = 10;
   localparam int RL    = 328;
   localparam int RH    = 330;
   localparam int TOTAL = BASE * N + A;
   localparam int MODHI = A * (BASE + 1);

   logic vco_clk   = 1'b0;
   logic ref_clk   = 1'b0;
   logic rst_n     = 1'b0;
   logic ps_en     = 1'b0;
   logic ratio_sel = 1'b0;
   logic ref_pulse;
   logic main_pulse;
   logic mod_ctl;

   int total = 0;
   int bad   = 0;

   // behavioural phase models
   int mp   = 0;
   bit mact = 0;
   int rq   = 0;
   int rlen = RL;
   bit ract = 0;

   int vcyc = 0;
   int rcyc = 0;
   int modcnt = 0;
   int save_cnt = 0;
   bit quiet_win = 0;
   int main_q[$];
   int mod_q[$];
   int ref_q[$];

   psw_divchain u0 (
      .vco_clk    (vco_clk),
      .ref_clk    (ref_clk),
      .rst_n      (rst_n),
      .ps_en      (ps_en),
      .ratio_sel  (ratio_sel),
      .ref_pulse  (ref_pulse),
      .main_pulse (main_pulse),
      .mod_ctl    (mod_ctl)
   );

   // 250 MHz oscillator-side clock, edges at odd ns
   initial begin
      #1;
      forever begin
         vco_clk = 1'b1; #2;
         vco_clk = 1'b0; #2;
      end
   end

   initial forever #10 ref_clk = ~ref_clk;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   always @(posedge vco_clk or negedge rst_n) begin
      if (!rst_n) begin
         mp = 0; mact = 0;
      end else begin
         if (!mact) mp = 0;
         else       mp = (mp + 1) % TOTAL;
         mact = ps_en;
      end
   end

   always @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         rq = 0; ract = 0;
      end else begin
         if (!ract) rq = 0;
         else if (rq == 0) begin
            rlen = ratio_sel ? RH : RL;
            rq = 1;
         end else if (rq == rlen - 1) rq = 0;
         else rq = rq + 1;
         ract = ps_en;
      end
   end

   always @(negedge vco_clk) begin
      bit exp_main;
      bit exp_mod;
      vcyc++;
      exp_main = mact && (mp == 0);
      exp_mod  = (mp >= 1) && (mp <= MODHI);
      chk(main_pulse === exp_main, "R2 main_pulse vs model", main_pulse, exp_main);
      chk(mod_ctl === exp_mod, "R3 mod_ctl vs model", mod_ctl, exp_mod);
      if (mod_ctl === 1'b1) modcnt++;
      if (main_pulse === 1'b1) begin
         main_q.push_back(vcyc);
         mod_q.push_back(modcnt);
         modcnt = 0;
         if (quiet_win) save_cnt++;
      end
   end

   always begin
      bit exp_ref;
      @(posedge ref_clk);
      #5;
      rcyc++;
      exp_ref = ract && (rq == 0);
      chk(ref_pulse === exp_ref, "R4 ref_pulse vs model", ref_pulse, exp_ref);
      if (ref_pulse === 1'b1) begin
         ref_q.push_back(rcyc);
         if (quiet_win) save_cnt++;
      end
   end

   task automatic summary();
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      #800000;
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", vcyc, 0);
      summary();
      $finish;
   end

   task automatic enable_and_check_first(input string tag);
      main_q.delete(); mod_q.delete(); ref_q.delete(); modcnt = 0;
      ps_en = 1'b1;
      quiet_win = 1'b0;
      @(negedge vco_clk);
      chk(main_pulse === 1'b1, {tag, " R7 first main pulse"}, main_pulse, 1);
      @(posedge ref_clk); #5;
      chk(ref_pulse === 1'b1, {tag, " R7 first ref pulse"}, ref_pulse, 1);
   endtask

   initial begin
      int n1;
      int n2;
      repeat (5) @(negedge ref_clk);
      // R1: reset state
      chk(main_pulse === 1'b0, "R1 reset main_pulse", main_pulse, 0);
      chk(ref_pulse === 1'b0, "R1 reset ref_pulse", ref_pulse, 0);
      chk(mod_ctl === 1'b0, "R1 reset mod_ctl", mod_ctl, 0);
      rst_n = 1'b1;
      quiet_win = 1'b1;
      repeat (20) @(negedge ref_clk);
      chk(save_cnt == 0, "R1 pulses while saving after reset", save_cnt, 0);
      chk(mod_ctl === 1'b0, "R1 mod_ctl in save", mod_ctl, 0);

      enable_and_check_first("start");
      while (main_q.size() < 5) @(negedge ref_clk);
      for (int i = 1; i < 5; i++) begin
         chk(main_q[i] - main_q[i-1] == TOTAL, "R2 main period", main_q[i] - main_q[i-1], TOTAL);
         chk(mod_q[i] == MODHI, "R3 divide-by-17 cycles per period", mod_q[i], MODHI);
      end
      for (int i = 1; i < ref_q.size(); i++)
         chk(ref_q[i] - ref_q[i-1] == RL, "R4 ref period sel=0", ref_q[i] - ref_q[i-1], RL);

      // R6: change in mid-count waits for the reload
      n1 = ref_q.size();
      while (ref_q.size() == n1) @(negedge ref_clk);
      repeat (100) @(negedge ref_clk);
      ratio_sel = 1'b1;
      n1 = ref_q.size();
      while (ref_q.size() < n1 + 3) @(negedge ref_clk);
      chk(ref_q[n1] - ref_q[n1-1] == RL, "R6 running period keeps old ratio",
          ref_q[n1] - ref_q[n1-1], RL);
      chk(ref_q[n1+1] - ref_q[n1] == RH, "R5 ref period sel=1", ref_q[n1+1] - ref_q[n1], RH);
      chk(ref_q[n1+2] - ref_q[n1+1] == RH, "R5 ref period sel=1 again",
          ref_q[n1+2] - ref_q[n1+1], RH);

      // R6: change made inside the pulse cycle applies to the next period
      n2 = ref_q.size();
      while (ref_q.size() == n2) @(negedge ref_clk);
      ratio_sel = 1'b0;
      while (ref_q.size() < n2 + 2) @(negedge ref_clk);
      chk(ref_q[n2+1] - ref_q[n2] == RL, "R6 select taken at reload", ref_q[n2+1] - ref_q[n2], RL);

      // R8: pulses never adjacent in the recorded stamps
      for (int i = 1; i < ref_q.size(); i++)
         chk(ref_q[i] - ref_q[i-1] > 1, "R8 ref pulses separated", ref_q[i] - ref_q[i-1], 2);

      // R9: power save in mid-period, then resume
      ps_en = 1'b0;
      quiet_win = 1'b1;
      save_cnt = 0;
      repeat (200) @(negedge ref_clk);
      chk(save_cnt == 0, "R9 no pulse during save", save_cnt, 0);
      chk(mod_ctl === 1'b0, "R1 mod_ctl low during save", mod_ctl, 0);
      enable_and_check_first("resume R9");
      while (main_q.size() < 2) @(negedge ref_clk);
      chk(main_q[1] - main_q[0] == TOTAL, "R9 main period after resume", main_q[1] - main_q[0], TOTAL);
      chk(mod_q[1] == MODHI, "R3 divide-by-17 cycles after resume", mod_q[1], MODHI);
      chk(ref_q[1] - ref_q[0] == RL, "R9 ref period after resume", ref_q[1] - ref_q[0], RL);

      summary();
      $finish;
   end
endmodule